// File: doc/BRIEF.md
# Peak-Tracking Hysteresis Switchpoint Detector

This block turns a stream of signed samples of a differential sensor signal into one digital level. That level changes once for each half-cycle of the signal. A tracking register stands in for a counting DAC. In the rising phase it climbs after the signal and keeps the highest value it has reached. When the signal falls far enough below that stored peak, the output switches and the tracker starts descending instead. In the falling phase it keeps the lowest value it has reached. When the signal climbs far enough above that stored valley, the output switches back.

The switching thresholds are set relative to the stored extreme, not fixed in absolute terms. For this reason the block only reacts to swing amplitude. A signal that changes arbitrarily slowly still produces clean transitions, because nothing in the block depends on how fast samples change. The distance that triggers a switch is set separately for each direction. Every output transition comes with a one-cycle pulse.

Top module: `peak_switch_detector`

## Requirements
- R1: While reset is held, and after it until a transition occurs, `outLevel` is 0 and `outToggle` is 0. The first valid sample after reset loads the tracker directly, starts the rising phase, and causes no transition.
- R2: In the rising phase the tracker moves up by exactly one LSB on each valid sample that is greater than it. It stays unchanged when the sample is equal or lower. It never jumps to the sample value.
- R3: In the rising phase, a valid sample strictly below (tracker − operate hysteresis) sets `outLevel` to 1 and enters the falling phase. A sample exactly equal to that threshold does not switch. The tracker holds its value on the switching sample.
- R4: In the falling phase the tracker moves down by exactly one LSB on each valid sample that is lower than it. It stays unchanged when the sample is equal or higher.
- R5: In the falling phase, a valid sample strictly above (tracker + release hysteresis) clears `outLevel` to 0 and enters the rising phase. A sample exactly equal to that threshold does not switch.
- R6: The hysteresis value used for a phase is taken when that phase begins. The operate value is taken on the priming sample and on each switch into the rising phase. The release value is taken on each switch into the falling phase. Changing an input in the middle of a phase has no effect until the next phase.
- R7: `outToggle` is high for exactly the one cycle after each transition of `outLevel`, and is low at all other times.
- R8: Thresholds saturate at the signed full-scale limits of the sample width. A tracker near either limit combined with a large hysteresis therefore never wraps into a false switch.
- R9: While `sampleValid` is low, `sampleIn` is ignored. The tracker, phase and output all hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleIn` for this cycle |
| sampleIn | input | SAMPLE_W | Signed two's-complement sample |
| hystOperate | input | HYST_W | Unsigned drop from peak needed to switch the output high |
| hystRelease | input | HYST_W | Unsigned rise from valley needed to switch the output low |
| outLevel | output | 1 | Switched digital output |
| outToggle | output | 1 | One-cycle pulse on each transition of `outLevel` |

## Verification
The bench first drives a large input jump. It then offers a sample that would switch only if the tracker had leapt to that jump, so a design that loads the sample instead of stepping would switch early. Samples exactly on the operate and release thresholds catch a comparison that is off by one, because such a design would switch one sample too soon. Changing the operate hysteresis partway through a rising phase catches a design that uses the live input: it would fail to switch on the expected sample. Near both full-scale limits, a threshold that wraps instead of saturating produces a spurious transition. A stream of extreme samples with the valid strobe low would drag a tracker that ignores the strobe far enough to move the next switch point.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic {
    PH_UP   = 1'b0,
    PH_DOWN = 1'b1
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSample;
    logic stepUp;
    logic stepDown;
    logic takeOperate;
    logic takeRelease;
  } dpCtrl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic aboveTrk;
    logic belowTrk;
    logic belowLow;
    logic aboveHigh;
  } dpFlags_t;

endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int HYST_W   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [HYST_W-1:0]   hystOperate,
  input  logic        [HYST_W-1:0]   hystRelease,
  input  dpCtrl_t                    ctrl,
  output dpFlags_t                   flags
);

  localparam int EXT_W = ((HYST_W > SAMPLE_W) ? HYST_W : SAMPLE_W) + 2;
  localparam int MAX_I = (1 << (SAMPLE_W - 1)) - 1;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'(MAX_I);
  localparam logic signed [EXT_W-1:0] MIN_V = EXT_W'(-MAX_I - 1);

  logic signed [SAMPLE_W-1:0] trk;
  logic        [HYST_W-1:0]   hystReg;

  logic signed [EXT_W-1:0] trkX, sampleX, hystX;
  logic signed [EXT_W-1:0] lowRaw, highRaw, thrLow, thrHigh;

  always_comb begin
    trkX    = EXT_W'(trk);
    sampleX = EXT_W'(sampleIn);
    hystX   = signed'(EXT_W'(hystReg));
    lowRaw  = trkX - hystX;
    highRaw = trkX + hystX;
    thrLow  = (lowRaw < MIN_V) ? MIN_V : lowRaw;
    thrHigh = (highRaw > MAX_V) ? MAX_V : highRaw;
    flags.aboveTrk  = sampleIn > trk;
    flags.belowTrk  = sampleIn < trk;
    flags.belowLow  = sampleX < thrLow;
    flags.aboveHigh = sampleX > thrHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trk     <= '0;
      hystReg <= '0;
    end else begin
      if (ctrl.loadSample)    trk <= sampleIn;
      else if (ctrl.stepUp)   trk <= trk + SAMPLE_W'(1);
      else if (ctrl.stepDown) trk <= trk - SAMPLE_W'(1);
      if (ctrl.takeOperate)      hystReg <= hystOperate;
      else if (ctrl.takeRelease) hystReg <= hystRelease;
    end
  end

  // R2/R4: outside priming, the tracker moves by at most one LSB
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadSample |=> (trk == $past(trk)) || (trk == $past(trk) + SAMPLE_W'(1))
                         || (trk == $past(trk) - SAMPLE_W'(1)));

  // R8: saturated thresholds bracket the tracker
  p_thr_bracket_r8: assert property (@(posedge clk) disable iff (!rstN)
    (thrLow <= trkX) && (thrHigh >= trkX));

endmodule

// File: rtl/psd_control.sv
module psd_control
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  dpFlags_t flags,
  output dpCtrl_t  ctrl,
  output logic     outLevel,
  output logic     outToggle
);

  phase_t phase;
  logic   primed;
  logic   switchNow;

  always_comb begin
    ctrl      = '0;
    switchNow = 1'b0;
    if (sampleValid) begin
      if (!primed) begin
        ctrl.loadSample  = 1'b1;
        ctrl.takeOperate = 1'b1;
      end else if (phase == PH_UP) begin
        if (flags.belowLow) begin
          switchNow        = 1'b1;
          ctrl.takeRelease = 1'b1;
        end else if (flags.aboveTrk) begin
          ctrl.stepUp = 1'b1;
        end
      end else begin
        if (flags.aboveHigh) begin
          switchNow        = 1'b1;
          ctrl.takeOperate = 1'b1;
        end else if (flags.belowTrk) begin
          ctrl.stepDown = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_UP;
      primed    <= 1'b0;
      outLevel  <= 1'b0;
      outToggle <= 1'b0;
    end else begin
      outToggle <= switchNow;
      if (sampleValid && !primed) begin
        primed <= 1'b1;
        phase  <= PH_UP;
      end
      if (switchNow) begin
        outLevel <= ~outLevel;
        phase    <= (phase == PH_UP) ? PH_DOWN : PH_UP;
      end
    end
  end

  // R7: every toggle pulse marks a real level change
  p_toggle_marks_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    outToggle |-> (outLevel != $past(outLevel)));

  // R9: no valid sample, no change of level
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(outLevel) && !outToggle);

  // R2: upward step only toward a higher input
  p_step_up_toward_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepUp |-> flags.aboveTrk);

  // R4: downward step only toward a lower input
  p_step_down_toward_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepDown |-> flags.belowTrk);

  // R2/R4: at most one tracker action per cycle
  p_single_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadSample, ctrl.stepUp, ctrl.stepDown}));

endmodule

// File: rtl/peak_switch_detector.sv
module peak_switch_detector
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int HYST_W   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [HYST_W-1:0]   hystOperate,
  input  logic        [HYST_W-1:0]   hystRelease,
  output logic                       outLevel,
  output logic                       outToggle
);

  dpCtrl_t  ctrl;
  dpFlags_t flags;

  psd_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .HYST_W  (HYST_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleIn   (sampleIn),
    .hystOperate(hystOperate),
    .hystRelease(hystRelease),
    .ctrl       (ctrl),
    .flags      (flags)
  );

  psd_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .flags      (flags),
    .ctrl       (ctrl),
    .outLevel   (outLevel),
    .outToggle  (outToggle)
  );

endmodule

// File: tb/peak_switch_detector_bench.sv
module peak_switch_detector_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SW = 12;
  localparam int HW = 10;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 sampleValid = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic        [HW-1:0] hystOperate = '0;
  logic        [HW-1:0] hystRelease = '0;
  logic                 outLevel;
  logic                 outToggle;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  peak_switch_detector #(.SAMPLE_W(SW), .HYST_W(HW)) u_peak_switch_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .hystOperate(hystOperate), .hystRelease(hystRelease),
    .outLevel(outLevel), .outToggle(outToggle)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 level in reset", outLevel, 1'b0);
    check("R1 toggle in reset", outToggle, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one valid sample; outputs read 1 ns after the capturing edge
  task automatic push(input int s);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = SW'(s);
    @(posedge clk);
    #1;
    sampleValid = 1'b0;
  endtask

  task automatic idleCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic testPrimeAndClimb();
    hystOperate = 5;
    hystRelease = 5;
    push(0);
    check("R1 priming sample causes no switch", outLevel, 1'b0);
    check("R1 no toggle on priming", outToggle, 1'b0);
    repeat (3) push(100);
    check("R2 climbing holds low", outLevel, 1'b0);
    push(-2);  // tracker 3, threshold -2: equal, no switch
    check("R2 tracker stepped, did not jump", outLevel, 1'b0);
    check("R3 equal to threshold does not switch", outToggle, 1'b0);
    push(-3);
    check("R3 switch high below peak", outLevel, 1'b1);
    check("R7 toggle on rise", outToggle, 1'b1);
    idleCycle();
    check("R7 toggle is one cycle", outToggle, 1'b0);
  endtask

  task automatic testFallAndRelease();
    repeat (15) push(-10);  // tracker 3 -> -10 then holds
    check("R4 descending holds level", outLevel, 1'b1);
    push(-5);
    check("R5 equal to release threshold", outLevel, 1'b1);
    push(-4);
    check("R5 switch low above valley", outLevel, 1'b0);
    check("R7 toggle on fall", outToggle, 1'b1);
  endtask

  task automatic testHystLatch();
    hystOperate = 50;  // mid-phase change, must not apply
    repeat (10) push(0);  // tracker -10 -> 0
    push(-5);
    check("R6 latched operate, equal no switch", outLevel, 1'b0);
    push(-6);
    check("R6 latched operate switches", outLevel, 1'b1);
  endtask

  task automatic testIgnoreInvalid();
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = SW'(-2048);
    repeat (6) @(posedge clk);
    #1;
    check("R9 level holds while invalid", outLevel, 1'b1);
    check("R9 no toggle while invalid", outToggle, 1'b0);
    push(5);  // tracker still 0, release 5: equal, no switch
    check("R9 tracker untouched by invalid", outLevel, 1'b1);
    push(6);
    check("R9 switch at expected point", outLevel, 1'b0);
  endtask

  task automatic testSaturation();
    hystOperate = 20;
    hystRelease = 20;
    doReset();
    push(-2040);
    push(-2048);
    check("R8 low threshold saturates", outLevel, 1'b0);
    push(-2048);
    check("R8 low threshold no wrap", outToggle, 1'b0);
    hystOperate = 1;
    doReset();
    push(2040);
    push(2038);
    check("R3 switch near top", outLevel, 1'b1);
    push(2047);
    check("R8 high threshold saturates", outLevel, 1'b1);
    check("R8 high threshold no toggle", outToggle, 1'b0);
  endtask

  initial begin
    doReset();
    testPrimeAndClimb();
    testFallAndRelease();
    testHystLatch();
    testIgnoreInvalid();
    testSaturation();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule